// File: doc/BRIEF.md
# Serial Line Transmitter with Programmable Framing

This block is the sending side of an asynchronous serial port. Software writes through a small register interface: a data register that queues bytes, a line-control register that selects word length, parity, stop bits, queue mode and a break condition, two registers that together hold a 12-bit bit-rate divisor, and a control register whose bit 0 enables the port. Queued bytes are serialised on a single output line that idles high.

In queue mode the block holds up to 16 bytes. In single-entry mode it holds one byte. Two flags tell software whether another byte can be accepted and whether the transmitter has fully drained. Software is expected to clear the enable bit before it rewrites the divisor or line control, and to set it again afterwards. A byte is never handed out while the port is disabled, so bytes can be preloaded and then released.

Top module: `uatx_top`

## Requirements
- R1: After reset the line output is 1, the full flag is 0 and the busy flag is 0.
- R2: A frame is a start bit of 0, then the data bits LSB first, then stop bits of 1. Line-control bits 6:5 set the number of data bits (00=5, 01=6, 10=7, 11=8), and data bits above that count are not sent. The line is 1 between frames.
- R3: Line-control bit 1 adds a parity bit after the data. Bit 2 set selects even parity, where the parity bit is the XOR of the sent data bits. Bit 2 clear selects odd parity, which is the inverse of that XOR.
- R4: Line-control bit 3 set gives two stop bits; clear gives one.
- R5: Every bit lasts 16*(N+1) clock cycles. N is 12 bits: its bits 7:0 are written at address 2 and its bits 11:8 come from bits 3:0 of a write to address 3. Address 0 is the data register, address 1 is line control and address 4 is control.
- R6: With line-control bit 4 set, up to 16 bytes are queued, they are sent in write order, and the full flag is 1 once 16 are waiting.
- R7: With line-control bit 4 clear, the block holds a single byte, and the full flag is 1 once one byte is waiting.
- R8: A data write made while the full flag is 1 is dropped. That byte never appears on the line, and the bytes already queued are unchanged.
- R9: The busy flag is 1 while any byte is queued or a frame is being shifted out, and returns to 0 only after the last stop bit.
- R10: While line-control bit 0 is 1, the line is held at 0 once the frame in progress has finished. Queued bytes wait, and they go out after the bit is cleared.
- R11: While control bit 0 is 0, no frame starts, any frame in progress is abandoned and the line stays idle. Writes are still queued.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register select |
| wr_data | input | 8 | Write data |
| txd | output | 1 | Serial line output |
| fifo_full | output | 1 | No further byte can be accepted |
| tx_busy | output | 1 | Data queued or being shifted |

## Verification
The assertions assume that the queue mode bit is only changed while the queue is empty, because lowering it over a deeper queue would leave more than one byte in single-entry mode. They also assume that the divisor and the word format are changed only while the port is disabled or idle. The bench keeps to this. Before it rewrites any setting, it waits for the busy flag to fall or holds the enable bit at 0. The random frames draw the format and a small divisor between idle periods, and the break is raised only as a line-control write in which the format is unchanged.

// File: rtl/uatx_pkg.sv
package uatx_pkg;
   localparam int DATA_W  = 8;
   localparam int FRAME_W = 12;

   localparam logic [2:0] A_DATA = 3'd0;
   localparam logic [2:0] A_LCTL = 3'd1;
   localparam logic [2:0] A_DLO  = 3'd2;
   localparam logic [2:0] A_DMID = 3'd3;
   localparam logic [2:0] A_CTRL = 3'd4;

   typedef struct packed {
      logic [1:0] wlen;
      logic       fifo_en;
      logic       two_stop;
      logic       par_even;
      logic       par_en;
      logic       brk;
   } line_ctl_t;
endpackage

// File: rtl/uatx_fifo.sv
module uatx_fifo #(
   parameter int DEPTH = 16,
   parameter int W     = 8,
   localparam int AW   = $clog2(DEPTH),
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [W-1:0]  wdata,
   input  logic          pop,
   input  logic          deep,
   output logic [W-1:0]  rdata,
   output logic          empty,
   output logic          full,
   output logic [CW-1:0] count
);
   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wptr, rptr, wnext, rnext;
   logic          do_push, do_pop;

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("uatx_fifo: DEPTH must be at least 2");
      end
      if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
         assign wnext = wptr + 1'b1;
         assign rnext = rptr + 1'b1;
      end else begin : g_wrap
         assign wnext = (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
         assign rnext = (rptr == AW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
      end
   endgenerate

   assign empty   = (count == '0);
   assign full    = deep ? (count == CW'(DEPTH)) : !empty;
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign rdata   = mem[rptr];

   always_ff @(posedge clk) begin
      if (do_push) mem[wptr] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr  <= '0;
         rptr  <= '0;
         count <= '0;
      end else begin
         if (do_push) wptr <= wnext;
         if (do_pop)  rptr <= rnext;
         case ({do_push, do_pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end
endmodule

// File: rtl/uatx_baud.sv
module uatx_baud #(
   parameter int DIV_W = 12,
   localparam int CNT_W = DIV_W + 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             restart,
   input  logic [DIV_W-1:0] div,
   output logic             tick
);
   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] lim;

   assign lim  = {div, 4'hF};
   assign tick = run && !restart && (cnt == lim);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   cnt <= '0;
      else if (!run || restart)     cnt <= '0;
      else if (cnt == lim)          cnt <= '0;
      else                          cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/uatx_framer.sv
module uatx_framer
   import uatx_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  line_ctl_t         lctl,
   input  logic              q_empty,
   input  logic [DATA_W-1:0] q_data,
   input  logic              tick,
   output logic              start,
   output logic              active,
   output logic              txd
);
   logic [FRAME_W-1:0] sreg, frame;
   logic [3:0]         left, len, wl;
   logic               par;

   assign start = en && !lctl.brk && !q_empty && !active;
   assign txd   = active ? sreg[0] : !lctl.brk;

   always_comb begin
      wl       = 4'd5 + {2'b00, lctl.wlen};
      frame    = '1;
      frame[0] = 1'b0;
      par      = 1'b0;
      for (int i = 0; i < DATA_W; i++) begin
         if (i < int'(wl)) begin
            frame[1 + i] = q_data[i];
            par          = par ^ q_data[i];
         end
      end
      if (lctl.par_en) frame[4'd1 + wl] = lctl.par_even ? par : !par;
      len = 4'd1 + wl + {3'b000, lctl.par_en} + (lctl.two_stop ? 4'd2 : 4'd1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sreg   <= '1;
         left   <= '0;
         active <= 1'b0;
      end else if (!en) begin
         sreg   <= '1;
         left   <= '0;
         active <= 1'b0;
      end else if (start) begin
         sreg   <= frame;
         left   <= len;
         active <= 1'b1;
      end else if (active && tick) begin
         sreg <= {1'b1, sreg[FRAME_W-1:1]};
         left <= left - 1'b1;
         if (left == 4'd1) active <= 1'b0;
      end
   end
endmodule

// File: rtl/uatx_top.sv
module uatx_top
   import uatx_pkg::*;
#(
   parameter int DEPTH = 16,
   parameter int DIV_W = 12,
   localparam int MID_W = DIV_W - 8,
   localparam int CW    = $clog2(DEPTH + 1)
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_en,
   input  logic [2:0] wr_addr,
   input  logic [7:0] wr_data,
   output logic       txd,
   output logic       fifo_full,
   output logic       tx_busy
);
   generate
      if (DIV_W < 9 || DIV_W > 16) begin : g_bad_div
         $error("uatx_top: DIV_W must lie in 9..16");
      end
   endgenerate

   line_ctl_t         lctl;
   logic [7:0]        div_lo;
   logic [MID_W-1:0]  div_mid;
   logic              port_en;
   logic              push, q_empty, sh_start, sh_active, tick;
   logic [DATA_W-1:0] q_data;
   logic [CW-1:0]     q_count;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lctl    <= 7'h60;
         div_lo  <= '0;
         div_mid <= '0;
         port_en <= 1'b0;
      end else if (wr_en) begin
         case (wr_addr)
            A_LCTL:  lctl    <= wr_data[6:0];
            A_DLO:   div_lo  <= wr_data;
            A_DMID:  div_mid <= wr_data[MID_W-1:0];
            A_CTRL:  port_en <= wr_data[0];
            default: ;
         endcase
      end
   end

   assign push    = wr_en && (wr_addr == A_DATA);
   assign tx_busy = !q_empty || sh_active;

   uatx_fifo #(.DEPTH(DEPTH), .W(DATA_W)) i_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (push),
      .wdata (wr_data),
      .pop   (sh_start),
      .deep  (lctl.fifo_en),
      .rdata (q_data),
      .empty (q_empty),
      .full  (fifo_full),
      .count (q_count)
   );

   uatx_baud #(.DIV_W(DIV_W)) i_baud (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (port_en),
      .restart (sh_start),
      .div     ({div_mid, div_lo}),
      .tick    (tick)
   );

   uatx_framer i_framer (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (port_en),
      .lctl    (lctl),
      .q_empty (q_empty),
      .q_data  (q_data),
      .tick    (tick),
      .start   (sh_start),
      .active  (sh_active),
      .txd     (txd)
   );
endmodule

// File: rtl/uatx_checker.sv
module uatx_checker
   import uatx_pkg::*;
#(
   parameter int DEPTH = 16,
   localparam int CW = $clog2(DEPTH + 1)
) (
   input logic          clk,
   input logic          rst_n,
   input logic          wr_en,
   input logic [2:0]    wr_addr,
   input logic          txd,
   input logic          fifo_full,
   input logic          tx_busy,
   input logic          brk,
   input logic          port_en,
   input logic          sh_start,
   input logic          sh_active,
   input logic [CW-1:0] q_count
);
   assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
      q_count <= CW'(DEPTH));

   assert_drop_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_full && wr_en && wr_addr == A_DATA && !sh_start) |=> $stable(q_count));

   assert_busy_queued_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (q_count != '0) |-> tx_busy);

   assert_break_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (brk && !sh_active) |-> !txd);

   assert_break_no_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (brk && !sh_active) |=> !sh_active);

   assert_disable_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !port_en |=> !sh_active);

   assert_start_bit_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sh_active) |-> !txd);
endmodule

bind uatx_top uatx_checker #(.DEPTH(DEPTH)) i_uatx_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .wr_en     (wr_en),
   .wr_addr   (wr_addr),
   .txd       (txd),
   .fifo_full (fifo_full),
   .tx_busy   (tx_busy),
   .brk       (lctl.brk),
   .port_en   (port_en),
   .sh_start  (sh_start),
   .sh_active (sh_active),
   .q_count   (q_count)
);

// File: tb/test_uatx_top.sv
module test_uatx_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [2:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic       txd, fifo_full, tx_busy;
   int         errors = 0;
   int         checks = 0;

   always #5 clk = ~clk;

   uatx_top i_uatx_top (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_addr   (wr_addr),
      .wr_data   (wr_data),
      .txd       (txd),
      .fifo_full (fifo_full),
      .tx_busy   (tx_busy)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic wait_idle();
      while (tx_busy !== 1'b0) @(negedge clk);
   endtask

   function automatic logic [11:0] exp_frame(input logic [7:0] lc, input logic [7:0] d,
                                             output int len);
      int   wl;
      logic p;
      logic [11:0] f;
      wl = 5 + int'(lc[6:5]);
      f = '1; f[0] = 1'b0; p = 1'b0;
      for (int i = 0; i < wl; i++) begin
         f[1 + i] = d[i];
         p = p ^ d[i];
      end
      if (lc[1]) f[1 + wl] = lc[2] ? p : ~p;
      len = 1 + wl + int'(lc[1]) + (lc[3] ? 2 : 1);
      return f;
   endfunction

   task automatic capture(input int len, input int per, output logic [11:0] got);
      got = '1;
      while (txd !== 1'b0) @(negedge clk);
      repeat (per / 2) @(negedge clk);
      for (int i = 0; i < len; i++) begin
         got[i] = txd;
         if (i < len - 1) repeat (per) @(negedge clk);
      end
   endtask

   task automatic send_check(input string req, input logic [7:0] lc, input logic [7:0] d,
                             input int per);
      logic [11:0] e, g;
      int len;
      e = exp_frame(lc, d, len);
      capture(len, per, g);
      check(req, {20'd0, g}, {20'd0, e});
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      logic [7:0] lc, d;
      int n, cyc;
      void'($urandom(32'd2024));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1 txd", {31'd0, txd}, 32'd1);
      check("R1 full", {31'd0, fifo_full}, 32'd0);
      check("R1 busy", {31'd0, tx_busy}, 32'd0);

      // R5 divisor across both registers: N = 0x100, 8N1, data 0x00 -> 9 low bits
      wr(3'd2, 8'h00);
      wr(3'd3, 8'hF1);
      wr(3'd1, 8'h60);
      wr(3'd4, 8'h01);
      wr(3'd0, 8'h00);
      while (txd !== 1'b0) @(negedge clk);
      cyc = 0;
      while (txd === 1'b0) begin
         @(negedge clk);
         cyc++;
      end
      check("R5 low time", cyc, 9 * 16 * 257);
      wait_idle();
      check("R9 busy clears", {31'd0, tx_busy}, 32'd0);
      wr(3'd3, 8'h00);

      // R2 R3 R4 R5 random formats and small divisors
      for (int k = 0; k < 20; k++) begin
         wait_idle();
         n  = $urandom % 4;
         lc = {1'b0, 2'($urandom), 1'b0, 3'($urandom), 1'b0};
         d  = 8'($urandom);
         wr(3'd4, 8'h00);
         wr(3'd2, 8'(n));
         wr(3'd1, lc);
         wr(3'd4, 8'h01);
         wr(3'd0, d);
         send_check("R2 R3 R4 R5 frame", lc, d, 16 * (n + 1));
      end
      // directed: 5 bits odd parity two stop, upper data bits not sent
      wait_idle();
      wr(3'd2, 8'h00);
      wr(3'd1, 8'h0A);
      wr(3'd0, 8'hE3);
      send_check("R2 R3 R4 5-bit odd 2-stop", 8'h0A, 8'hE3, 16);

      // R6 deep queue, preloaded while disabled (R11)
      wait_idle();
      wr(3'd4, 8'h00);
      wr(3'd1, 8'h70);
      for (int k = 0; k < 16; k++) wr(3'd0, 8'(k * 17 + 3));
      check("R6 full at 16", {31'd0, fifo_full}, 32'd1);
      repeat (100) @(negedge clk);
      check("R11 idle while disabled", {31'd0, txd}, 32'd1);
      check("R9 busy while queued", {31'd0, tx_busy}, 32'd1);
      wr(3'd0, 8'hEE);
      wr(3'd4, 8'h01);
      for (int k = 0; k < 16; k++)
         send_check("R6 order", 8'h70, 8'(k * 17 + 3), 16);
      repeat (400) @(negedge clk);
      check("R8 dropped byte not sent", {31'd0, txd}, 32'd1);
      check("R8 queue empty", {31'd0, tx_busy}, 32'd0);

      // R7 single holding register
      wr(3'd4, 8'h00);
      wr(3'd1, 8'h60);
      wr(3'd0, 8'hA5);
      check("R7 full after one", {31'd0, fifo_full}, 32'd1);
      wr(3'd0, 8'h5A);
      wr(3'd4, 8'h01);
      send_check("R7 R8 held byte", 8'h60, 8'hA5, 16);
      repeat (400) @(negedge clk);
      check("R8 second byte dropped", {31'd0, txd}, 32'd1);
      check("R8 idle", {31'd0, tx_busy}, 32'd0);

      // R10 break after the current frame
      wr(3'd0, 8'h3C);
      wr(3'd1, 8'h61);
      send_check("R10 frame completes", 8'h60, 8'h3C, 16);
      repeat (200) @(negedge clk);
      check("R10 line held low", {31'd0, txd}, 32'd0);
      wr(3'd0, 8'h81);
      repeat (200) @(negedge clk);
      check("R10 queued byte waits", {31'd0, txd}, 32'd0);
      check("R10 busy while waiting", {31'd0, tx_busy}, 32'd1);
      wr(3'd1, 8'h60);
      send_check("R10 byte after release", 8'h60, 8'h81, 16);
      wait_idle();
      @(negedge clk);
      check("R2 idle high", {31'd0, txd}, 32'd1);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule